// File: doc/BRIEF.md
# Capture Timer with Event Counter

This block is a 16-bit up-counter with a power-of-two prescaler, driven through an 8-bit register bus. In its plain timer mode it counts prescaler ticks, or rising edges of an external input. In capture mode it measures the input. It counts while the input sits between a start edge and a stop edge, so the result is either a pulse width or a period.

A 10-bit event counter extends a capture over several input cycles. Each stop edge decrements it, and the measurement ends when it reaches its last count. The measurement can therefore be the sum of several pulses, or the length of several consecutive periods.

Software reads the 16-bit count through the 8-bit bus without tearing. Reading the low byte freezes the high byte in a shadow register. A high-byte write waits until the low-byte write, so both bytes change in the same cycle. A single interrupt flag reports a counter wrap and the end of a measurement.

Top module: `pulse_capture_timer`

## Requirements
- R1: Register addresses are 0 mode, 1 capture control, 2 count low, 3 count high, 4 event low and 5 event high. After reset every register reads 0, and `irqFlag` and `tickOut` are 0.
- R2: The mode register bits are: bit 7 enable, bits 6:4 rate r, bit 3 source, bit 0 interrupt flag. While the block is enabled, with source 0 and start 0, the counter advances once every 2^(7-r) clocks from the enabling write, and `tickOut` is high in exactly those cycles. When the enable is 0 the counter holds its value.
- R3: With source 1 (and start 0), the counter advances once per rising edge of `capIn`, each seen after a two-flop synchronizer.
- R4: The capture-control register bits are: bit 7 event enable, bit 3 capture clock (1 = every clock, 0 = prescaler tick), bit 2 start, bits 1:0 edge mode. With edge mode 01 and capture clock 1, a high pulse of H clocks adds H to the counter. At the stop edge, start clears and the interrupt flag sets. The counter then holds until the capture-control register is written again, whatever the input does.
- R5: Edge mode 00 measures a low pulse: a falling edge starts the count and the next rising edge stops it, giving the width in clocks.
- R6: Edge mode 10 (rise to rise) and edge mode 11 (fall to fall) count continuously from the first start edge. With the event enable set and an event count N≥1, counting ends at the N-th following edge of the same kind, so the counter gains N whole periods. The event count ends at 0.
- R7: With a pulse edge mode (00 or 01) and the event enable set with count N, the counter accumulates the widths of N pulses. The gaps between pulses are not counted.
- R8: An increment from FFFFh wraps the counter to 0000h, counting continues without reload, and the interrupt flag sets. Writing 1 to mode bit 0 clears the flag.
- R9: Reading the count low byte copies the current high byte into a shadow register. A read of the count high byte returns that shadow, even after the counter has changed.
- R10: A write of the count high byte alone leaves the counter unchanged. The next low-byte write loads both bytes together.
- R11: Only bits 1:0 of the event high register exist. Its bits 7:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (triggers the shadow capture) |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| capIn | input | 1 | Capture or external count input |
| tickOut | output | 1 | Prescaled clock enable |
| irqFlag | output | 1 | Interrupt request flag |

## Verification
High pulses and low pulses of random width, with the capture clock at full rate, show whether the start and stop edges are paired correctly and the count is off by none. Periodic trains in rise-to-rise and fall-to-fall modes, including one run with an event count above 255, separate period accumulation from pulse accumulation and exercise the upper event bits. Free-running runs of random length at random rates test the prescaler's division. Runs that start just below FFFFh show the wrap and the flag. Interleaved byte reads and writes tell the shadow and staged registers apart from direct access to the counter.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_EVT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_EVT_HI = 3'd5;

  typedef enum logic [1:0] {
    EDGE_LOW_PULSE  = 2'b00,
    EDGE_HIGH_PULSE = 2'b01,
    EDGE_PER_RISE   = 2'b10,
    EDGE_PER_FALL   = 2'b11
  } edgeMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic evtDec;
  } ctStrobe_t;
endpackage

// File: rtl/ct_sync.sv
`timescale 1ns/1ps
module ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ct_control.sv
`timescale 1ns/1ps
module ct_control
  import ct_pkg::*;
#(
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              capIn,
  input  logic              evtLast,
  input  logic              evtNonZero,
  input  logic              ovfPulse,
  output ctStrobe_t         strobe,
  output logic [BUS_W-1:0]  modeByte,
  output logic [BUS_W-1:0]  ctrlByte,
  output logic              tickOut,
  output logic              irqFlag,
  output logic              finish
);
  localparam int PRESC_W = (1 << RATE_W) - 1;

  logic              enable, srcExt, irq;
  logic [RATE_W-1:0] rate;
  logic              evtEn, capFast, start, measuring, held;
  edgeMode_t         edgeMode;
  logic [PRESC_W-1:0] presc, mask;
  logic capS, capPrev, rise, fall, startEv, stopEv;
  logic tick, capTick, modeWr, ctrlWr, active, stopHit;

  ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(capIn), .dout(capS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capPrev <= 1'b0;
    else       capPrev <= capS;
  end

  assign rise = capS & ~capPrev;
  assign fall = ~capS & capPrev;

  always_comb begin
    unique case (edgeMode)
      EDGE_LOW_PULSE:  begin startEv = fall; stopEv = rise; end
      EDGE_HIGH_PULSE: begin startEv = rise; stopEv = fall; end
      EDGE_PER_RISE:   begin startEv = rise; stopEv = rise; end
      default:         begin startEv = fall; stopEv = fall; end
    endcase
  end

  // prescaler: rate r divides by 2^(PRESC_W - r)
  assign mask = {PRESC_W{1'b1}} >> rate;
  assign tick = enable && ((presc & mask) == mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        presc <= '0;
    else if (!enable) presc <= '0;
    else              presc <= presc + 1'b1;
  end

  assign modeWr  = wrEn && (addr == ADDR_MODE);
  assign ctrlWr  = wrEn && (addr == ADDR_CTRL);
  assign capTick = capFast | tick;
  assign active  = enable & start;
  assign stopHit = active & measuring & stopEv;
  assign finish  = stopHit & (~evtEn | evtLast);

  always_comb begin
    strobe.evtDec = stopHit & evtEn & evtNonZero;
    if (!enable || held)  strobe.cntInc = 1'b0;
    else if (start)       strobe.cntInc = measuring & capTick;
    else                  strobe.cntInc = srcExt ? rise : tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      rate   <= '0;
      srcExt <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (modeWr) begin
        enable <= wrData[BUS_W-1];
        rate   <= wrData[BUS_W-2 -: RATE_W];
        srcExt <= wrData[BUS_W-2-RATE_W];
      end
      irq <= (irq & ~(modeWr & wrData[0])) | ovfPulse | finish;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtEn     <= 1'b0;
      capFast   <= 1'b0;
      start     <= 1'b0;
      edgeMode  <= EDGE_LOW_PULSE;
      measuring <= 1'b0;
      held      <= 1'b0;
    end else if (ctrlWr) begin
      evtEn     <= wrData[BUS_W-1];
      capFast   <= wrData[3];
      start     <= wrData[2];
      edgeMode  <= edgeMode_t'(wrData[1:0]);
      measuring <= 1'b0;
      held      <= 1'b0;
    end else if (finish) begin
      start     <= 1'b0;
      measuring <= 1'b0;
      held      <= 1'b1;
    end else if (!active) begin
      measuring <= 1'b0;
    end else if (!measuring && startEv) begin
      measuring <= 1'b1;
    end else if (stopHit && !edgeMode[1]) begin
      measuring <= 1'b0;
    end
  end

  assign modeByte = {enable, rate, srcExt, {(BUS_W-RATE_W-3){1'b0}}, irq};
  assign ctrlByte = {evtEn, {(BUS_W-5){1'b0}}, capFast, start, edgeMode};
  assign tickOut  = tick;
  assign irqFlag  = irq;
endmodule

// File: rtl/ct_datapath.sv
`timescale 1ns/1ps
module ct_datapath
  import ct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EVT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  ctStrobe_t         strobe,
  output logic [BUS_W-1:0]  cntLoByte,
  output logic [BUS_W-1:0]  shadowByte,
  output logic [BUS_W-1:0]  evtLoByte,
  output logic [BUS_W-1:0]  evtHiByte,
  output logic              evtLast,
  output logic              evtNonZero,
  output logic              ovfPulse
);
  localparam int HI_W  = CNT_W - BUS_W;
  localparam int EHI_W = EVT_W - BUS_W;

  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  pendHi, shadow;
  logic [EVT_W-1:0] evt;

  assign ovfPulse = strobe.cntInc & (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      pendHi <= '0;
      shadow <= '0;
    end else begin
      if (wrEn && addr == ADDR_CNT_HI) pendHi <= wrData[HI_W-1:0];
      if (wrEn && addr == ADDR_CNT_LO) cnt <= {pendHi, wrData};
      else if (strobe.cntInc)          cnt <= cnt + 1'b1;
      if (rdEn && addr == ADDR_CNT_LO) shadow <= cnt[CNT_W-1:BUS_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evt <= '0;
    else if (wrEn && addr == ADDR_EVT_LO) evt[BUS_W-1:0] <= wrData;
    else if (wrEn && addr == ADDR_EVT_HI) evt[EVT_W-1:BUS_W] <= wrData[EHI_W-1:0];
    else if (strobe.evtDec) evt <= evt - 1'b1;
  end

  assign evtLast    = (evt <= {{(EVT_W-1){1'b0}}, 1'b1});
  assign evtNonZero = |evt;
  assign cntLoByte  = cnt[BUS_W-1:0];
  assign shadowByte = shadow;
  assign evtLoByte  = evt[BUS_W-1:0];
  assign evtHiByte  = {{(BUS_W-EHI_W){1'b0}}, evt[EVT_W-1:BUS_W]};
endmodule

// File: rtl/pulse_capture_timer.sv
`timescale 1ns/1ps
module pulse_capture_timer
  import ct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int EVT_W       = 10,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              capIn,
  output logic              tickOut,
  output logic              irqFlag
);
  ctStrobe_t        strobe;
  logic [BUS_W-1:0] modeByte, ctrlByte, cntLoByte, shadowByte, evtLoByte, evtHiByte;
  logic             evtLast, evtNonZero, ovfPulse, finish;

  ct_control #(.RATE_W(RATE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wrData(busWrData),
    .capIn(capIn), .evtLast(evtLast), .evtNonZero(evtNonZero), .ovfPulse(ovfPulse),
    .strobe(strobe), .modeByte(modeByte), .ctrlByte(ctrlByte),
    .tickOut(tickOut), .irqFlag(irqFlag), .finish(finish)
  );

  ct_datapath #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrData(busWrData), .strobe(strobe), .cntLoByte(cntLoByte),
    .shadowByte(shadowByte), .evtLoByte(evtLoByte), .evtHiByte(evtHiByte),
    .evtLast(evtLast), .evtNonZero(evtNonZero), .ovfPulse(ovfPulse)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_MODE:   busRdData = modeByte;
      ADDR_CTRL:   busRdData = ctrlByte;
      ADDR_CNT_LO: busRdData = cntLoByte;
      ADDR_CNT_HI: busRdData = shadowByte;
      ADDR_EVT_LO: busRdData = evtLoByte;
      ADDR_EVT_HI: busRdData = evtHiByte;
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: rtl/ct_checker.sv
`timescale 1ns/1ps
module ct_checker
  import ct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EVT_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BUS_W-1:0]  busRdData,
  input logic              irqFlag,
  input logic              ovfPulse,
  input logic              finish,
  input logic              startBit,
  input logic              enable,
  input logic              evtDec,
  input logic [CNT_W-1:0]  cnt,
  input logic [EVT_W-1:0]  evt
);
  logic ctrlWr, cntLoWr, evtWr;
  assign ctrlWr  = busWrEn && busAddr == ADDR_CTRL;
  assign cntLoWr = busWrEn && busAddr == ADDR_CNT_LO;
  assign evtWr   = busWrEn && (busAddr == ADDR_EVT_LO || busAddr == ADDR_EVT_HI);

  p_ovf_sets_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> irqFlag);

  p_done_clears_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (finish && !ctrlWr) |=> !startBit);

  p_evt_hi_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_EVT_HI) |-> (busRdData[BUS_W-1:EVT_W-BUS_W] == '0));

  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cntLoWr) |=> $stable(cnt));

  p_evt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evtDec && !evtWr) |=> (evt == $past(evt) - 1'b1));
endmodule

bind pulse_capture_timer ct_checker #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
  .busRdData(busRdData), .irqFlag(irqFlag), .ovfPulse(u_dp.ovfPulse),
  .finish(u_ctl.finish), .startBit(u_ctl.start), .enable(u_ctl.enable),
  .evtDec(u_ctl.strobe.evtDec), .cnt(u_dp.cnt), .evt(u_dp.evt)
);

// File: tb/sim_pulse_capture_timer.sv
`timescale 1ns/1ps
module sim_pulse_capture_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0, capIn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0, busRdData;
  logic       tickOut, irqFlag;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 1'b0;

  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_CLO = 3'd2,
                         A_CHI = 3'd3, A_ELO = 3'd4, A_EHI = 3'd5;

  pulse_capture_timer u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .capIn(capIn),
    .tickOut(tickOut), .irqFlag(irqFlag)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] expFree(input int m, input int r);
    return 16'((m + 1) >> (7 - r));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    busRdEn = 1'b1; busAddr = a;
    #1 v = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(A_CLO, lo);
    rd(A_CHI, hi);
    v = {hi, lo};
  endtask

  task automatic setCnt(input logic [15:0] v);
    wr(A_CHI, v[15:8]);
    wr(A_CLO, v[7:0]);
  endtask

  task automatic pulse(input logic lvl, input int w, input int gap);
    capIn = lvl;
    repeat (w) @(negedge clk);
    capIn = ~lvl;
    repeat (gap) @(negedge clk);
  endtask

  task automatic cleanSlate();
    capIn = 1'b0;
    wr(A_MODE, 8'h01);
    wr(A_CTRL, 8'h00);
    setCnt(16'h0000);
    repeat (4) @(negedge clk);
  endtask

  logic [7:0]  b;
  logic [15:0] v, v2;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), b);
      chk("R1 reset register", {8'h0, b}, 16'h0);
    end
    chk("R1 reset irq", {15'h0, irqFlag}, 16'h0);
    chk("R1 reset tick", {15'h0, tickOut}, 16'h0);

    // R2 disabled counter holds
    setCnt(16'h1234);
    repeat (50) @(negedge clk);
    rd16(v);
    chk("R2 hold when disabled", v, 16'h1234);

    // R10 staged high write
    wr(A_CHI, 8'hAB);
    rd16(v);
    chk("R10 high write alone", v, 16'h1234);
    wr(A_CLO, 8'hCD);
    rd16(v);
    chk("R10 paired commit", v, 16'hABCD);

    // R9 shadow read
    setCnt(16'h12FF);
    rd(A_CLO, b);
    chk("R9 low byte", {8'h0, b}, 16'h00FF);
    setCnt(16'h5678);
    rd(A_CHI, b);
    chk("R9 shadow high", {8'h0, b}, 16'h0012);
    rd16(v);
    chk("R9 fresh read", v, 16'h5678);

    // R11 event high width
    wr(A_EHI, 8'hFF);
    rd(A_EHI, b);
    chk("R11 event high mask", {8'h0, b}, 16'h0003);
    wr(A_ELO, 8'h5A);
    rd(A_ELO, b);
    chk("R11 event low", {8'h0, b}, 16'h005A);

    // R2 free-running at random rates
    for (int i = 0; i < 6; i++) begin
      int r, m;
      r = (i == 0) ? 7 : int'($urandom % 8);
      m = int'($urandom % 300);
      cleanSlate();
      wr(A_MODE, 8'(8'h81 | (r << 4)));
      if (r == 7) chk("R2 tick every clock", {15'h0, tickOut}, 16'h1);
      repeat (m) @(negedge clk);
      wr(A_MODE, 8'(r << 4));
      chk("R2 tick off when disabled", {15'h0, tickOut}, 16'h0);
      rd16(v);
      chk("R2 prescaled count", v, expFree(m, r));
    end

    // R3 external source
    begin
      int k;
      k = 1 + int'($urandom % 20);
      cleanSlate();
      wr(A_MODE, 8'h89);
      for (int i = 0; i < k; i++) pulse(1'b1, 3, 3);
      repeat (5) @(negedge clk);
      wr(A_MODE, 8'h08);
      rd16(v);
      chk("R3 edge count", v, 16'(k));
    end

    // R4 high-pulse width, random plus corner widths
    for (int i = 0; i < 7; i++) begin
      int h;
      h = (i == 0) ? 1 : (i == 1) ? 2 : 1 + int'($urandom % 60);
      cleanSlate();
      wr(A_MODE, 8'h81);
      wr(A_CTRL, 8'h0D);
      repeat (3) @(negedge clk);
      pulse(1'b1, h, 8);
      rd16(v);
      chk("R4 high width", v, 16'(h));
      rd(A_CTRL, b);
      chk("R4 start cleared", {8'h0, b}, 16'h0009);
      chk("R4 irq set", {15'h0, irqFlag}, 16'h1);
      pulse(1'b1, 5, 300);
      rd16(v2);
      chk("R4 result held", v2, 16'(h));
    end

    // R5 low-pulse width
    for (int i = 0; i < 3; i++) begin
      int l;
      l = 1 + int'($urandom % 50);
      cleanSlate();
      capIn = 1'b1;
      repeat (5) @(negedge clk);
      wr(A_MODE, 8'h81);
      wr(A_CTRL, 8'h0C);
      repeat (3) @(negedge clk);
      pulse(1'b0, l, 8);
      rd16(v);
      chk("R5 low width", v, 16'(l));
      chk("R5 irq set", {15'h0, irqFlag}, 16'h1);
    end

    // R6 periods with event counter: long rise run, then random fall runs
    for (int i = 0; i < 4; i++) begin
      int n, a, c;
      logic fallMode;
      fallMode = (i != 0);
      n = (i == 0) ? 260 : 1 + int'($urandom % 6);
      a = (i == 0) ? 2 : 1 + int'($urandom % 5);
      c = (i == 0) ? 3 : 1 + int'($urandom % 5);
      cleanSlate();
      wr(A_EHI, 8'(n >> 8));
      wr(A_ELO, 8'(n));
      wr(A_MODE, 8'h81);
      wr(A_CTRL, fallMode ? 8'h8F : 8'h8E);
      repeat (3) @(negedge clk);
      for (int p = 0; p <= n; p++) pulse(1'b1, a, c);
      repeat (8) @(negedge clk);
      rd16(v);
      chk("R6 period sum", v, 16'(n * (a + c)));
      rd(A_ELO, b);
      chk("R6 event low zero", {8'h0, b}, 16'h0);
      rd(A_EHI, b);
      chk("R6 event high zero", {8'h0, b}, 16'h0);
      rd(A_CTRL, b);
      chk("R6 start cleared", {8'h0, b}, fallMode ? 16'h008B : 16'h008A);
      chk("R6 irq set", {15'h0, irqFlag}, 16'h1);
    end

    // R7 accumulated pulse widths
    for (int i = 0; i < 3; i++) begin
      int n, sum;
      n = 2 + int'($urandom % 4);
      sum = 0;
      cleanSlate();
      wr(A_EHI, 8'h00);
      wr(A_ELO, 8'(n));
      wr(A_MODE, 8'h81);
      wr(A_CTRL, 8'h8D);
      repeat (3) @(negedge clk);
      for (int p = 0; p < n; p++) begin
        int w, g;
        w = 1 + int'($urandom % 20);
        g = 2 + int'($urandom % 6);
        sum += w;
        pulse(1'b1, w, g);
      end
      repeat (8) @(negedge clk);
      rd16(v);
      chk("R7 pulse sum", v, 16'(sum));
      chk("R7 irq set", {15'h0, irqFlag}, 16'h1);
    end

    // R8 wrap and interrupt
    cleanSlate();
    setCnt(16'hFFF0);
    chk("R8 irq clear before", {15'h0, irqFlag}, 16'h0);
    wr(A_MODE, 8'hF1);
    repeat (29) @(negedge clk);
    wr(A_MODE, 8'h70);
    rd16(v);
    chk("R8 wrapped count", v, 16'h000E);
    chk("R8 irq set", {15'h0, irqFlag}, 16'h1);
    rd(A_MODE, b);
    chk("R8 mode readback", {8'h0, b}, 16'h0071);
    wr(A_MODE, 8'h01);
    chk("R8 irq cleared", {15'h0, irqFlag}, 16'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule